// File: doc/BRIEF.md
# Instruction Repeat Counter Unit

This unit sequences the repetition of a coprocessor instruction. A start pulse begins a repeat sequence. The count for the sequence comes either from a 5-bit immediate carried with the pulse or from a 13-bit count register that software can write. The datapath reports each finished execution with an iteration-done pulse. In that same cycle the unit answers with a "repeat again" strobe while work remains. It keeps a repeat-active flag high until the final execution has completed.

The count register holds the number of executions still to come, minus one. A register value of N therefore yields N+1 executions. An immediate value is stored as the immediate minus one. When an execution completes, the unit tests the count: at zero the sequence ends, otherwise the count is decremented and the instruction runs again. An interrupt entry pulse freezes the sequence with its flag and remaining count intact, and the matching return pulse resumes it.

Top module: `iter_repeat_unit`

## Requirements
- R1: While reset is asserted and after it is released, `active_o` is 0, `cnt_o` is 0 and `again_o` is 0.
- R2: A `start_i` pulse while idle with `start_use_reg_i`=0 loads `cnt_o` with `start_imm_i`-1 on the next cycle, or with 0 when the immediate is 0, and sets `active_o` on the next cycle.
- R3: A `start_i` pulse while idle with `start_use_reg_i`=1 keeps the count register value N, and the sequence completes after exactly N+1 `iter_done_i` pulses.
- R4: While running, an `iter_done_i` with a non-zero count and no `irq_enter_i` raises `again_o` in the same cycle, and `cnt_o` is one lower on the next cycle.
- R5: While running, an `iter_done_i` with a zero count leaves `again_o` low and clears `active_o` on the next cycle.
- R6: While running, `irq_enter_i` suspends the sequence. `again_o` is low in that cycle. A coincident `iter_done_i` with a non-zero count still decrements the count. While suspended, `active_o` stays 1, `cnt_o` holds, and `iter_done_i` has no effect.
- R7: `irq_return_i` while suspended resumes the sequence on the next cycle, and the remaining iterations then complete as in R4 and R5.
- R8: `start_i` is ignored while a sequence is active, whether running or suspended.
- R9: A write through `cnt_we_i` updates `cnt_o` on the next cycle only when idle with no accepted start in the same cycle. Writes at any other time are dropped.
- R10: A count of 8191, the 13-bit maximum, gives 8192 executions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a repeat sequence |
| start_use_reg_i | input | 1 | 1: take count from register; 0: from immediate |
| start_imm_i | input | 5 | Immediate repeat count |
| cnt_we_i | input | 1 | Count register write enable |
| cnt_wdata_i | input | 13 | Count register write data |
| iter_done_i | input | 1 | Datapath finished one execution |
| irq_enter_i | input | 1 | Interrupt routine entered |
| irq_return_i | input | 1 | Interrupt routine returned |
| again_o | output | 1 | Issue the instruction once more |
| active_o | output | 1 | Repeat sequence in progress |
| cnt_o | output | 13 | Count register value |

## Verification
The assertions check the following on every cycle:
- A repeat strobe only occurs with a non-zero count while running, and is followed by a decrement.
- A final iteration clears the active flag.
- The count and flag hold while suspended.
- A return resumes the sequence.
- The count stays put between iterations.

Only the bench scenarios can show the following, because each depends on a whole sequence:
- The exact number of executions for immediate and register counts, including the 8192-execution maximum.
- The minus-one load of an immediate and the treatment of a zero immediate.
- The dropping of writes and start requests that collide with an active sequence or an accepted start.

// File: rtl/iter_repeat_pkg.sv
package iter_repeat_pkg;
  localparam int unsigned CNT_W_DEF = 13;
  localparam int unsigned IMM_W_DEF = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } rpt_state_e;
endpackage

// File: rtl/iter_repeat_load.sv
module iter_repeat_load #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned IMM_W = 5
) (
  input  logic             use_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [CNT_W-1:0] cnt_q_i,
  output logic [CNT_W-1:0] load_val_o
);
  logic [IMM_W-1:0] imm_m1;
  logic [CNT_W-1:0] imm_ext;

  // zero immediate means one execution
  assign imm_m1 = (imm_i == '0) ? '0 : imm_i - 1'b1;

  generate
    if (CNT_W > IMM_W) begin : g_ext
      assign imm_ext = {{(CNT_W-IMM_W){1'b0}}, imm_m1};
    end else begin : g_trunc
      assign imm_ext = imm_m1[CNT_W-1:0];
    end
  endgenerate

  assign load_val_o = use_reg_i ? cnt_q_i : imm_ext;
endmodule

// File: rtl/iter_repeat_count.sv
module iter_repeat_count #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_en_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic             cnt_zero_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q_o <= '0;
    end else if (load_en_i) begin
      cnt_q_o <= load_val_i;
    end else if (dec_en_i) begin
      cnt_q_o <= cnt_q_o - 1'b1;
    end else if (wr_en_i) begin
      cnt_q_o <= wr_data_i;
    end
  end

  assign cnt_zero_o = (cnt_q_o == '0);
endmodule

// File: rtl/iter_repeat_fsm.sv
module iter_repeat_fsm
  import iter_repeat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic iter_done_i,
  input  logic irq_enter_i,
  input  logic irq_return_i,
  input  logic cnt_zero_i,
  output logic start_acc_o,
  output logic dec_en_o,
  output logic again_o,
  output logic idle_o,
  output logic active_o,
  output logic susp_o
);
  rpt_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (iter_done_i && cnt_zero_i) state_d = ST_IDLE;
        else if (irq_enter_i)          state_d = ST_SUSP;
      end
      ST_SUSP: if (irq_return_i) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign susp_o      = (state_q == ST_SUSP);
  assign active_o    = !idle_o;
  assign start_acc_o = idle_o && start_i;
  assign dec_en_o    = (state_q == ST_RUN) && iter_done_i && !cnt_zero_i;
  assign again_o     = dec_en_o && !irq_enter_i;
endmodule

// File: rtl/iter_repeat_unit.sv
module iter_repeat_unit
  import iter_repeat_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned IMM_W = IMM_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_use_reg_i,
  input  logic [IMM_W-1:0] start_imm_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             iter_done_i,
  input  logic             irq_enter_i,
  input  logic             irq_return_i,
  output logic             again_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             start_acc;
  logic             dec_en;
  logic             idle;
  logic             susp;
  logic             cnt_zero;
  logic             wr_en;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;

  iter_repeat_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .iter_done_i  (iter_done_i),
    .irq_enter_i  (irq_enter_i),
    .irq_return_i (irq_return_i),
    .cnt_zero_i   (cnt_zero),
    .start_acc_o  (start_acc),
    .dec_en_o     (dec_en),
    .again_o      (again_o),
    .idle_o       (idle),
    .active_o     (active_o),
    .susp_o       (susp)
  );

  iter_repeat_load #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_load (
    .use_reg_i  (start_use_reg_i),
    .imm_i      (start_imm_i),
    .cnt_q_i    (cnt_q),
    .load_val_o (load_val)
  );

  // software writes only land while no sequence owns the count
  assign wr_en = cnt_we_i && idle && !start_i;

  iter_repeat_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_i  (start_acc),
    .load_val_i (load_val),
    .dec_en_i   (dec_en),
    .wr_en_i    (wr_en),
    .wr_data_i  (cnt_wdata_i),
    .cnt_q_o    (cnt_q),
    .cnt_zero_o (cnt_zero)
  );

  assign cnt_o = cnt_q;
endmodule

// File: rtl/iter_repeat_chk.sv
module iter_repeat_chk #(
  parameter int unsigned CNT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             iter_done_i,
  input logic             irq_enter_i,
  input logic             irq_return_i,
  input logic             again_o,
  input logic             active_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             susp
);
  p_again_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    again_o |-> (cnt_o != '0 && active_o && !susp));

  p_again_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    again_o |=> (cnt_o == $past(cnt_o) - 1'b1));

  p_last_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !susp && iter_done_i && cnt_o == '0) |=> !active_o);

  p_irq_no_again_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_enter_i |-> !again_o);

  p_susp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp && !irq_return_i) |=> (susp && active_o && $stable(cnt_o)));

  p_resume_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp && irq_return_i) |=> (active_o && !susp));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && start_i) |=> active_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !iter_done_i) |=> $stable(cnt_o));
endmodule

bind iter_repeat_unit iter_repeat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .iter_done_i  (iter_done_i),
  .irq_enter_i  (irq_enter_i),
  .irq_return_i (irq_return_i),
  .again_o      (again_o),
  .active_o     (active_o),
  .cnt_o        (cnt_o),
  .susp         (susp)
);

// File: tb/iter_repeat_unit_test.sv
module iter_repeat_unit_test;
  localparam int CNT_W = 13;
  localparam int IMM_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             start_use_reg_i = 1'b0;
  logic [IMM_W-1:0] start_imm_i = '0;
  logic             cnt_we_i = 1'b0;
  logic [CNT_W-1:0] cnt_wdata_i = '0;
  logic             iter_done_i = 1'b0;
  logic             irq_enter_i = 1'b0;
  logic             irq_return_i = 1'b0;
  logic             again_o;
  logic             active_o;
  logic [CNT_W-1:0] cnt_o;

  always #5 clk_i = ~clk_i;

  iter_repeat_unit uut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_i),
    .start_use_reg_i (start_use_reg_i),
    .start_imm_i     (start_imm_i),
    .cnt_we_i        (cnt_we_i),
    .cnt_wdata_i     (cnt_wdata_i),
    .iter_done_i     (iter_done_i),
    .irq_enter_i     (irq_enter_i),
    .irq_return_i    (irq_return_i),
    .again_o         (again_o),
    .active_o        (active_o),
    .cnt_o           (cnt_o)
  );

  typedef struct {
    logic             again;
    logic             active;
    logic [CNT_W-1:0] cnt;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done_flag = 0;

  // reference state: 0 idle, 1 running, 2 suspended
  int               m_st  = 0;
  logic [CNT_W-1:0] m_cnt = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit st, input bit use_reg, input int imm,
                       input bit we, input int wd, input bit dn,
                       input bit ie, input bit ir, input string tag);
    exp_t e;
    @(negedge clk_i);
    start_i = st; start_use_reg_i = use_reg; start_imm_i = IMM_W'(imm);
    cnt_we_i = we; cnt_wdata_i = CNT_W'(wd); iter_done_i = dn;
    irq_enter_i = ie; irq_return_i = ir;
    e.again  = (m_st == 1) && dn && (m_cnt != 0) && !ie;
    e.active = (m_st != 0);
    e.cnt    = m_cnt;
    e.tag    = tag;
    exp_q.push_back(e);
    case (m_st)
      0: begin
        if (st) begin
          if (!use_reg) m_cnt = (imm == 0) ? '0 : CNT_W'(imm - 1);
          m_st = 1;
        end else if (we) m_cnt = CNT_W'(wd);
      end
      1: begin
        if (dn && m_cnt == 0) m_st = 0;
        else begin
          if (dn) m_cnt = m_cnt - 1'b1;
          if (ie) m_st = 2;
        end
      end
      default: if (ir) m_st = 1;
    endcase
  endtask

  task automatic idle_cyc(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(again_o === e.again, {e.tag, " again"}, int'(again_o), int'(e.again));
        chk(active_o === e.active, {e.tag, " active"}, int'(active_o), int'(e.active));
        chk(cnt_o === e.cnt, {e.tag, " cnt"}, int'(cnt_o), int'(e.cnt));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk(active_o === 1'b0 && cnt_o === '0 && again_o === 1'b0, "R1 in reset",
        int'(active_o), 0);
    rst_ni = 1'b1;
    idle_cyc("R1");
    idle_cyc("R1");

    // R2 / R4 / R5: immediate 5 -> count 4, five executions
    drive(1, 0, 5, 0, 0, 0, 0, 0, "R2 start");
    for (int i = 0; i < 5; i++) drive(0, 0, 0, 0, 0, 1, 0, 0, "R4 iter");
    idle_cyc("R5 end");
    idle_cyc("R5 idle");

    // R2: zero immediate is a single execution
    drive(1, 0, 0, 0, 0, 0, 0, 0, "R2 zero");
    drive(0, 0, 0, 0, 0, 1, 0, 0, "R5 single");
    idle_cyc("R5 after");

    // R2: immediate 31 -> 30
    drive(1, 0, 31, 0, 0, 0, 0, 0, "R2 max imm");
    idle_cyc("R2 loaded");
    for (int i = 0; i < 31; i++) drive(0, 0, 0, 0, 0, 1, 0, 0, "R4 imm31");
    idle_cyc("R5 imm31");

    // R9 / R3 / R8: register path
    drive(0, 0, 0, 1, 3, 0, 0, 0, "R9 write");
    drive(1, 1, 0, 1, 7, 0, 0, 0, "R9 write with start");
    drive(0, 0, 0, 1, 100, 0, 0, 0, "R9 write running");
    drive(1, 0, 9, 0, 0, 0, 0, 0, "R8 start running");
    idle_cyc("R8 check");
    n = 0;
    for (int i = 0; i < 10; i++) begin
      drive(0, 0, 0, 0, 0, 1, 0, 0, "R3 iter");
      #3;
      n++;
      if (!again_o) break;
    end
    chk(n == 4, "R3 executions", n, 4);
    idle_cyc("R3 end");

    // R6 / R7: interrupt
    drive(1, 0, 4, 0, 0, 0, 0, 0, "R6 start");
    drive(0, 0, 0, 0, 0, 1, 0, 0, "R4 pre irq");
    drive(0, 0, 0, 0, 0, 0, 1, 0, "R6 enter");
    drive(0, 0, 0, 0, 0, 1, 0, 0, "R6 done ignored");
    drive(1, 0, 2, 0, 0, 0, 0, 0, "R8 start suspended");
    drive(0, 0, 0, 1, 50, 0, 0, 0, "R9 write suspended");
    drive(0, 0, 0, 0, 0, 0, 0, 1, "R7 return");
    drive(0, 0, 0, 0, 0, 1, 1, 0, "R6 done with enter");
    drive(0, 0, 0, 0, 0, 0, 0, 1, "R7 return 2");
    drive(0, 0, 0, 0, 0, 1, 0, 0, "R7 iter");
    drive(0, 0, 0, 0, 0, 1, 0, 0, "R7 last");
    idle_cyc("R7 end");
    drive(0, 0, 0, 0, 0, 0, 1, 0, "R6 enter idle");
    idle_cyc("R6 idle");

    // R10: full 13-bit count
    drive(0, 0, 0, 1, 8191, 0, 0, 0, "R10 write");
    drive(1, 1, 0, 0, 0, 0, 0, 0, "R10 start");
    n = 0;
    for (int i = 0; i < 9000; i++) begin
      drive(0, 0, 0, 0, 0, 1, 0, 0, "R10 iter");
      #3;
      n++;
      if (!again_o) break;
    end
    chk(n == 8192, "R10 executions", n, 8192);
    idle_cyc("R10 end");
    idle_cyc("R10 idle");

    @(negedge clk_i);
    #5;
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule